// File: doc/BRIEF.md
# Card Interface Control Register Slave (I2C)

This block is the host-side control port of a smart-card interface device. An I2C master running at up to 400 kHz reaches it over SCL and SDA. SDA is driven open-drain: the block only ever pulls the line low, through an output enable. Three strap inputs select one of eight bus addresses on a fixed base, so eight devices can share one bus. The block finds START and STOP conditions and matches the address byte. On a write it loads each following data byte into a single 8-bit control register. On a read it returns that register first and then an externally supplied status byte.

Each bit of the control register is brought out as a registered control line for the rest of the device: activation request, warm reset, supply select, clock stop, clock stop level, clock divider select and I/O path enable. The warm-reset bit clears itself when the card starts answering or is declared mute. Both bus lines pass through two-flop synchronizers into the system clock domain. The system clock must run at least eight times faster than SCL.

Top module: `card_ctrl_i2c_slave`

## Requirements
- R1: After synchronous reset the control register is 0x00, every control output is low and SDA is released (sda_oe_o low).
- R2: The slave acknowledges, by pulling SDA low during the ninth clock, an address byte whose upper seven bits equal 0x20 OR addr_sel_i. The address byte is 0x40 + 2*addr_sel_i, and its bit 0 is the read flag (1 = read).
- R3: An address byte that does not match is not acknowledged. SDA then stays released, and later bytes have no effect, until the next START.
- R4: In a write transfer (read flag 0), each data byte that follows the address is acknowledged and replaces the control register contents. The last complete byte before STOP is the one that remains.
- R5: Control register bits decode as follows: bit 0 activation request (act_o), bit 1 warm reset (warm_rst_o), bit 2 3 V supply select (vcc_3v_o), bit 3 clock stop (clk_stop_o), bit 4 clock stop level high (clk_stop_hi_o), bits 6:5 clock divider select (clk_div_o, bit 6 as MSB), bit 7 I/O path enable (io_en_o).
- R6: A one-cycle pulse on card_answer_i or card_mute_i clears control bit 1 and leaves the other seven bits unchanged.
- R7: In a read transfer (read flag 1) the first byte returned, MSB first, is the control register. Each later byte is status_i, sampled when that byte begins. A NACK from the master ends the transfer and SDA is released.
- R8: A START received at any point, including in the middle of a byte, restarts address reception from the first bit.
- R9: A STOP received in the middle of a data byte discards the partial byte. The control register keeps its previous value.
- R10: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Pull SDA low when high, release when low |
| addr_sel_i | input | 3 | Address strap, added to the fixed base |
| status_i | input | 8 | Status byte returned after the register on reads |
| card_answer_i | input | 1 | Pulse: the card began answering |
| card_mute_i | input | 1 | Pulse: the card was declared mute |
| act_o | output | 1 | Activation request (register bit 0) |
| warm_rst_o | output | 1 | Warm reset request (bit 1) |
| vcc_3v_o | output | 1 | 3 V supply select, 5 V when low (bit 2) |
| clk_stop_o | output | 1 | Card clock stop (bit 3) |
| clk_stop_hi_o | output | 1 | Stopped clock level is high (bit 4) |
| clk_div_o | output | 2 | Card clock divider select (bits 6:5) |
| io_en_o | output | 1 | I/O data path enable (bit 7) |

## Verification
A bit counter that is off by one shows within the same transfer. The acknowledge lands on the wrong clock, so the master samples a high ACK on the ninth clock, or the register takes a shifted value that is visible on the control outputs right after STOP. A state machine stuck outside idle after a mismatch or a STOP shows at the next transfer as an acknowledge that should not happen, or as SDA held low during a master's bit. A wrong hardware-clear path shows on warm_rst_o two clocks after the pulse.

// File: rtl/cci2c_pkg.sv
package cci2c_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = DATA_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } eng_state_t;
endpackage

// File: rtl/cci2c_line_sync.sv
module cci2c_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign q_o[g]    = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/cci2c_bit_engine.sv
module cci2c_bit_engine
  import cci2c_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_q_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-2:0] dev_addr_i,
  input  logic [DW-1:0] rd_first_i,
  input  logic [DW-1:0] rd_next_i,
  output logic          sda_oe_o,
  output logic          wr_stb_o,
  output logic [DW-1:0] wr_data_o,
  output eng_state_t    state_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  eng_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    rx_q;
  logic [DW-1:0]    tx_q;
  logic             rw_q;
  logic             nack_q;
  logic             oe_q;
  logic             stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && cnt_q != FULL) begin
              rx_q  <= {rx_q[DW-2:0], sda_q_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              if (state_q == ST_WR) begin
                stb_q   <= 1'b1;
                oe_q    <= 1'b1;
                state_q <= ST_WR_ACK;
              end else if (rx_q[DW-1:1] == dev_addr_i) begin
                rw_q    <= rx_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= rd_first_i;
                oe_q    <= ~rd_first_i[DW-1];
                state_q <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i && cnt_q != FULL) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
            end else if (scl_fall_i && cnt_q != '0) begin
              tx_q <= {tx_q[DW-2:0], 1'b0};
              oe_q <= ~tx_q[DW-2];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_q_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                tx_q    <= rd_next_i;
                oe_q    <= ~rd_next_i[DW-1];
                cnt_q   <= '0;
                state_q <= ST_RD;
              end
            end
          end
          default: begin
            oe_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_stb_o  = stb_q;
  assign wr_data_o = rx_q;
  assign state_o   = state_q;
endmodule

// File: rtl/cci2c_ctrl_reg.sv
module cci2c_ctrl_reg #(
  parameter int unsigned DW       = 8,
  parameter int unsigned WARM_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          hw_clear_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q <= '0;
    end else begin
      if (wr_stb_i) q_q <= wr_data_i;
      if (hw_clear_i) q_q[WARM_BIT] <= 1'b0;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/card_ctrl_i2c_slave.sv
module card_ctrl_i2c_slave
  import cci2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_W       = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic              card_answer_i,
  input  logic              card_mute_i,
  output logic              act_o,
  output logic              warm_rst_o,
  output logic              vcc_3v_o,
  output logic              clk_stop_o,
  output logic              clk_stop_hi_o,
  output logic [1:0]        clk_div_o,
  output logic              io_en_o
);
  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;

  logic [1:0]        line_q, line_rise, line_fall;
  logic              scl_q, start_det, stop_det;
  logic [ADDR_W-1:0] dev_addr;
  logic              wr_stb;
  logic [DATA_W-1:0] wr_data, ctrl_q;
  eng_state_t        eng_state;

  cci2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .d_i    ({sda_i, scl_i}),
    .q_o    (line_q),
    .rise_o (line_rise),
    .fall_o (line_fall)
  );

  assign scl_q     = line_q[IDX_SCL];
  assign start_det = line_fall[IDX_SDA] & scl_q;
  assign stop_det  = line_rise[IDX_SDA] & scl_q;
  assign dev_addr  = BASE_ADDR | {{(ADDR_W-SEL_W){1'b0}}, addr_sel_i};

  cci2c_bit_engine #(.DW(DATA_W)) eng_i (
    .clk        (clk),
    .rst        (rst),
    .scl_rise_i (line_rise[IDX_SCL]),
    .scl_fall_i (line_fall[IDX_SCL]),
    .sda_q_i    (line_q[IDX_SDA]),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .dev_addr_i (dev_addr),
    .rd_first_i (ctrl_q),
    .rd_next_i  (status_i),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .state_o    (eng_state)
  );

  cci2c_ctrl_reg #(.DW(DATA_W), .WARM_BIT(1)) reg_i (
    .clk        (clk),
    .rst        (rst),
    .wr_stb_i   (wr_stb),
    .wr_data_i  (wr_data),
    .hw_clear_i (card_answer_i | card_mute_i),
    .q_o        (ctrl_q)
  );

  assign act_o         = ctrl_q[0];
  assign warm_rst_o    = ctrl_q[1];
  assign vcc_3v_o      = ctrl_q[2];
  assign clk_stop_o    = ctrl_q[3];
  assign clk_stop_hi_o = ctrl_q[4];
  assign clk_div_o     = ctrl_q[6:5];
  assign io_en_o       = ctrl_q[7];
endmodule

// File: rtl/cci2c_slave_chk.sv
module cci2c_slave_chk
  import cci2c_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_q,
  input logic              sda_oe_o,
  input logic              start_det,
  input logic              stop_det,
  input logic              warm_rst_o,
  input logic              card_answer_i,
  input logic              card_mute_i,
  input logic [DATA_W-1:0] ctrl_q,
  input eng_state_t        eng_state
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl_q == '0 && !sda_oe_o));

  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ST_IDLE) |-> !sda_oe_o);

  a_r6_warm_clear: assert property (@(posedge clk) disable iff (rst)
    (card_answer_i || card_mute_i) |=> !warm_rst_o);

  a_r8_start_restart: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (eng_state == ST_ADDR && !sda_oe_o));

  a_r9_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (eng_state == ST_IDLE && !sda_oe_o));

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_q);
endmodule

bind card_ctrl_i2c_slave cci2c_slave_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .scl_q         (scl_q),
  .sda_oe_o      (sda_oe_o),
  .start_det     (start_det),
  .stop_det      (stop_det),
  .warm_rst_o    (warm_rst_o),
  .card_answer_i (card_answer_i),
  .card_mute_i   (card_mute_i),
  .ctrl_q        (ctrl_q),
  .eng_state     (eng_state)
);

// File: tb/card_ctrl_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module card_ctrl_i2c_slave_tb_top;
  localparam int HALF = 10;
  // {sel[2:0], target[2:0], data[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {3'd5, 3'd5, 8'hA5}, {3'd5, 3'd4, 8'h3C}, {3'd0, 3'd0, 8'h00},
    {3'd0, 3'd1, 8'hFF}, {3'd7, 3'd7, 8'h81}, {3'd3, 3'd3, 8'h7E},
    {3'd2, 3'd6, 8'h55}, {3'd6, 3'd6, 8'h2C}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'd0;
  logic [7:0] status = 8'h00;
  logic answer = 1'b0, mute = 1'b0;
  logic sda_oe, act, warm, v3, cstop, cstop_hi, io_en;
  logic [1:0] cdiv;
  logic sda_line;
  int total = 0, bad = 0, viol = 0;
  logic done = 1'b0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  card_ctrl_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .status_i(status), .card_answer_i(answer),
    .card_mute_i(mute), .act_o(act), .warm_rst_o(warm), .vcc_3v_o(v3),
    .clk_stop_o(cstop), .clk_stop_hi_o(cstop_hi), .clk_div_o(cdiv),
    .io_en_o(io_en)
  );

  // R10 monitor: the enable may only move while the bus clock is low
  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] outs();
    return {io_en, cdiv, cstop_hi, cstop, v3, warm, act};
  endfunction

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF/2);
    ack = (sda_line == 1'b0);
    tick(HALF/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF/2);
      d[i] = sda_line;
      tick(HALF/2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = nack; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [2:0] tgt, input logic [7:0] d);
    logic a1, a2;
    i2c_start();
    send_byte({4'b0100, tgt, 1'b0}, a1);
    send_byte(d, a2);
    i2c_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic ack, ack2;
    logic [7:0] d, exp_reg;
    tick(5);
    rst = 1'b0;
    tick(3);
    chk("R1 reg", outs(), 8'h00);
    chk("R1 sda_oe", sda_oe, 1'b0);

    // Vector table: address match / mismatch and register load
    exp_reg = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] s, t;
      logic [7:0] dv;
      {s, t, dv} = VEC[i];
      sel = s; tick(4);
      i2c_start();
      send_byte({4'b0100, t, 1'b0}, ack);
      chk((s == t) ? "R2 addr ack" : "R3 addr nack", ack, (s == t));
      send_byte(dv, ack2);
      chk((s == t) ? "R4 data ack" : "R3 data ignored", ack2, (s == t));
      i2c_stop();
      if (s == t) exp_reg = dv;
      chk((s == t) ? "R4 reg load" : "R3 reg unchanged", outs(), exp_reg);
    end

    // R5 field decode, 0xB6 = 1011_0110
    sel = 3'd1; tick(4);
    write_reg(3'd1, 8'hB6);
    chk("R5 act", act, 1'b0);
    chk("R5 warm", warm, 1'b1);
    chk("R5 vcc_3v", v3, 1'b1);
    chk("R5 clk_stop", cstop, 1'b0);
    chk("R5 clk_stop_hi", cstop_hi, 1'b1);
    chk("R5 clk_div", cdiv, 2'b01);
    chk("R5 io_en", io_en, 1'b1);
    write_reg(3'd1, 8'h40);
    chk("R5 clk_div msb", cdiv, 2'b10);

    // R6 hardware clear of warm reset bit
    write_reg(3'd1, 8'h83);
    chk("R6 preset", outs(), 8'h83);
    answer = 1'b1; tick(1); answer = 1'b0; tick(2);
    chk("R6 answer clears", outs(), 8'h81);
    write_reg(3'd1, 8'h03);
    mute = 1'b1; tick(1); mute = 1'b0; tick(2);
    chk("R6 mute clears", outs(), 8'h01);

    // R7 read: register, then status bytes
    write_reg(3'd1, 8'hC9);
    status = 8'h5A;
    i2c_start();
    send_byte(8'h43, ack);
    chk("R7 read addr ack", ack, 1'b1);
    read_byte(1'b0, d);
    chk("R7 first byte reg", d, 8'hC9);
    tick(8);
    status = 8'hC3;
    read_byte(1'b0, d);
    chk("R7 second byte status", d, 8'h5A);
    read_byte(1'b1, d);
    chk("R7 third byte status", d, 8'hC3);
    tick(8);
    chk("R7 released after nack", sda_oe, 1'b0);
    i2c_stop();

    // R4 multi-byte write keeps the last byte
    i2c_start();
    send_byte(8'h42, ack);
    send_byte(8'h12, ack);
    send_byte(8'h34, ack2);
    chk("R4 second byte ack", ack2, 1'b1);
    i2c_stop();
    chk("R4 last byte kept", outs(), 8'h34);

    // R8 repeated start in the middle of a byte
    i2c_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    i2c_start();
    send_byte(8'h42, ack);
    chk("R8 addr ack after restart", ack, 1'b1);
    send_byte(8'h99, ack2);
    i2c_stop();
    chk("R8 reg after restart", outs(), 8'h99);

    // R9 stop in the middle of a data byte
    i2c_start();
    send_byte(8'h42, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    i2c_stop();
    tick(4);
    chk("R9 partial byte dropped", outs(), 8'h99);
    chk("R9 sda released", sda_oe, 1'b0);

    chk("R10 sda_oe moved with scl high", viol, 0);
    finish_run();
  end
endmodule